// File: doc/BRIEF.md
# PHY Register Access Port Bridge

This block lets software reach a small byte-wide register space inside a card-interface PHY through a single 32-bit host register. Software writes one word that carries a PHY address, a write byte and two command bits. A PHY transfer starts only when a command bit goes from 0 to 1 between two successive writes of the word. The bridge then drives a one-cycle write or read strobe on a master-side PHY register interface. It reports completion through an acknowledge bit in the same word, and a read also returns the fetched byte in that word.

A PHY write therefore takes three bus writes. The first loads the address and data with both command bits clear. The second repeats that word with the write bit set. The third clears the write bit again, which also clears the acknowledge. A read follows the same three-step pattern with the read bit.

The PHY side is modelled by a small register file. It holds one delay setting per speed mode: SD high speed, SD default, the four UHS modes, and the eMMC legacy, SDR and DDR modes. This lets the bridge be exercised end to end.

Top module: `phy_port_bridge`

## Requirements
- R1: After reset the port word reads as zero, both PHY strobes are low and every PHY register holds zero.
- R2: The port word layout is: address in bits 7:0, write byte in bits 15:8, read byte in bits 23:16, write command in bit 24, read command in bit 25 and acknowledge in bit 26. A bus write stores bits 7:0, 15:8, 24 and 25. Bits 23:16 and bit 26 are not written by software, and bits 31:27 always read zero.
- R3: A bus write that takes bit 24 from 0 to 1, while no transfer is pending, drives `phy_wr_stb` high for exactly one cycle, starting at the clock edge that accepts the bus write. During that cycle `phy_addr` and `phy_wdata` carry bits 7:0 and 15:8 of that word.
- R4: Writing the word again with bit 24 still set issues no further write strobe.
- R5: A bus write that takes bit 25 from 0 to 1, while no transfer is pending, drives `phy_rd_stb` high for one cycle. At the next edge the addressed PHY byte is latched into bits 23:16.
- R6: The acknowledge bit (bit 26) becomes 1 at the clock edge that ends a write or read strobe.
- R7: A bus write with bits 25:24 both zero clears the acknowledge bit at that edge, provided no strobe is active in that cycle.
- R8: While the acknowledge bit is set or a strobe is active, a rising command bit starts no transfer.
- R9: If bits 24 and 25 both rise in the same bus write, only the PHY write is performed.
- R10: The PHY register file has addresses 0x00 to 0x08. A write to any higher address changes nothing, and a read of one returns zero.
- R11: The delay initialisation sequence stores 4 at 0x00, 4 at 0x01, 9 at 0x06, 2 at 0x07 and 3 at 0x08, and each value reads back through the port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write enable for the port word |
| bus_wdata | input | 32 | Word written to the port |
| bus_rdata | output | 32 | Current port word |
| phy_wr_stb | output | 1 | One-cycle PHY register write strobe |
| phy_rd_stb | output | 1 | One-cycle PHY register read strobe |
| phy_addr | output | 8 | PHY register address for the current transfer |
| phy_wdata | output | 8 | PHY write byte for the current transfer |
| phy_rdata | output | 8 | Byte returned by the PHY register file |

## Verification
A bus write is taken at one rising edge. Its address, data and command fields, and any clearing of the acknowledge, are visible right after that edge. A strobe caused by it is high for the following cycle. The acknowledge bit and any read byte appear one edge later still. The bench drives inputs on falling edges and compares the port word and both strobes with a behavioural model at every falling edge. The directed checks wait the matching number of falling edges before they sample each of these results.

// File: rtl/phy_port_pkg.sv
package phy_port_pkg;
  localparam int WORD_W    = 32;
  localparam int PHY_AW    = 8;
  localparam int PHY_DW    = 8;
  localparam int ADDR_LSB  = 0;
  localparam int WDAT_LSB  = 8;
  localparam int RDAT_LSB  = 16;
  localparam int WR_BIT    = 24;
  localparam int RD_BIT    = 25;
  localparam int ACK_BIT   = 26;
  localparam int USED_BITS = ACK_BIT + 1;

  typedef struct packed {
    logic              ack;
    logic              rd;
    logic              wr;
    logic [PHY_DW-1:0] rbyte;
    logic [PHY_DW-1:0] wbyte;
    logic [PHY_AW-1:0] addr;
  } port_word_t;
endpackage

// File: rtl/phy_cmd_arbiter.sv
module phy_cmd_arbiter (
  input  logic bus_wr,
  input  logic new_wr,
  input  logic new_rd,
  input  logic old_wr,
  input  logic old_rd,
  input  logic busy,
  output logic issue_wr,
  output logic issue_rd
);
  logic wr_rise;
  logic rd_rise;

  always_comb begin
    wr_rise  = new_wr & ~old_wr;
    rd_rise  = new_rd & ~old_rd;
    issue_wr = bus_wr & ~busy & wr_rise;
    issue_rd = bus_wr & ~busy & rd_rise & ~wr_rise;
  end
endmodule

// File: rtl/phy_port_slave.sv
module phy_port_slave
  import phy_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [PHY_DW-1:0] rd_byte,
  output logic [PHY_AW-1:0] cmd_addr,
  output logic [PHY_DW-1:0] cmd_wdata,
  output logic              wr_stb,
  output logic              rd_stb
);
  port_word_t        word_q, word_d;
  logic              wstb_q, wstb_d;
  logic              rstb_q, rstb_d;
  logic [PHY_AW-1:0] caddr_q, caddr_d;
  logic [PHY_DW-1:0] cwd_q, cwd_d;
  logic              busy;
  logic              issue_wr;
  logic              issue_rd;
  logic              strobing;
  logic [PHY_AW-1:0] in_addr;
  logic [PHY_DW-1:0] in_wbyte;
  logic              in_wr;
  logic              in_rd;

  always_comb begin
    in_addr  = bus_wdata[ADDR_LSB +: PHY_AW];
    in_wbyte = bus_wdata[WDAT_LSB +: PHY_DW];
    in_wr    = bus_wdata[WR_BIT];
    in_rd    = bus_wdata[RD_BIT];
    strobing = wstb_q | rstb_q;
    busy     = word_q.ack | strobing;
  end

  phy_cmd_arbiter u_arb (
    .bus_wr   (bus_wr),
    .new_wr   (in_wr),
    .new_rd   (in_rd),
    .old_wr   (word_q.wr),
    .old_rd   (word_q.rd),
    .busy     (busy),
    .issue_wr (issue_wr),
    .issue_rd (issue_rd)
  );

  always_comb begin
    word_d  = word_q;
    caddr_d = caddr_q;
    cwd_d   = cwd_q;
    wstb_d  = 1'b0;
    rstb_d  = 1'b0;
    if (strobing) begin
      word_d.ack = 1'b1;
    end
    if (rstb_q) begin
      word_d.rbyte = rd_byte;
    end
    if (bus_wr) begin
      word_d.addr  = in_addr;
      word_d.wbyte = in_wbyte;
      word_d.wr    = in_wr;
      word_d.rd    = in_rd;
      if (!in_wr && !in_rd && !strobing) begin
        word_d.ack = 1'b0;
      end
    end
    if (issue_wr) begin
      wstb_d  = 1'b1;
      caddr_d = in_addr;
      cwd_d   = in_wbyte;
    end else if (issue_rd) begin
      rstb_d  = 1'b1;
      caddr_d = in_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      wstb_q  <= 1'b0;
      rstb_q  <= 1'b0;
      caddr_q <= '0;
      cwd_q   <= '0;
    end else begin
      word_q <= word_d;
      wstb_q <= wstb_d;
      rstb_q <= rstb_d;
      if (issue_wr || issue_rd) begin
        caddr_q <= caddr_d;
        cwd_q   <= cwd_d;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    bus_rdata[USED_BITS-1:0] = word_q;
  end

  assign cmd_addr  = caddr_q;
  assign cmd_wdata = cwd_q;
  assign wr_stb    = wstb_q;
  assign rd_stb    = rstb_q;
endmodule

// File: rtl/phy_delay_regfile.sv
module phy_delay_regfile #(
  parameter int NUM_REGS = 9,
  parameter int AW       = 8,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [NUM_REGS];
  logic [DW-1:0] mem_d [NUM_REGS];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == AW'(i)) begin
        rdata = mem_q[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      mem_d[i] = mem_q[i];
      if (addr == AW'(i)) begin
        mem_d[i] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        mem_q[i] <= '0;
      end
    end else if (wr_stb) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        mem_q[i] <= mem_d[i];
      end
    end
  end
endmodule

// File: rtl/phy_port_bridge.sv
module phy_port_bridge
  import phy_port_pkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              phy_wr_stb,
  output logic              phy_rd_stb,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [PHY_DW-1:0] phy_wdata,
  output logic [PHY_DW-1:0] phy_rdata
);
  logic [PHY_DW-1:0] rf_rdata;

  phy_port_slave u_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rd_byte   (rf_rdata),
    .cmd_addr  (phy_addr),
    .cmd_wdata (phy_wdata),
    .wr_stb    (phy_wr_stb),
    .rd_stb    (phy_rd_stb)
  );

  phy_delay_regfile #(
    .NUM_REGS (NUM_REGS),
    .AW       (PHY_AW),
    .DW       (PHY_DW)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (phy_wr_stb),
    .addr   (phy_addr),
    .wdata  (phy_wdata),
    .rdata  (rf_rdata)
  );

  assign phy_rdata = rf_rdata;
endmodule

// File: rtl/phy_port_bridge_chk.sv
module phy_port_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        phy_wr_stb,
  input logic        phy_rd_stb,
  input logic [7:0]  phy_rdata
);
  p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr_stb |=> !phy_wr_stb);

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_wr_stb, phy_rd_stb}));

  p_ack_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_wr_stb || phy_rd_stb) |=> bus_rdata[26]);

  p_read_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rd_stb |=> (bus_rdata[23:16] == $past(phy_rdata)));

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[25:24] == 2'b00 && !phy_wr_stb && !phy_rd_stb)
      |=> !bus_rdata[26]);

  p_pending_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rdata[26]) |=> !(phy_wr_stb || phy_rd_stb));

  p_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:27] == 5'b0);
endmodule

bind phy_port_bridge phy_port_bridge_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .phy_wr_stb (phy_wr_stb),
  .phy_rd_stb (phy_rd_stb),
  .phy_rdata  (phy_rdata)
);

// File: tb/phy_port_bridge_test.sv
`timescale 1ns/1ps
module phy_port_bridge_test;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        phy_wr_stb;
  logic        phy_rd_stb;
  logic [7:0]  phy_addr;
  logic [7:0]  phy_wdata;
  logic [7:0]  phy_rdata;

  int checks   = 0;
  int failures = 0;
  int wr_count = 0;
  int rd_count = 0;
  bit done     = 0;

  phy_port_bridge uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .phy_wr_stb (phy_wr_stb),
    .phy_rd_stb (phy_rd_stb),
    .phy_addr   (phy_addr),
    .phy_wdata  (phy_wdata),
    .phy_rdata  (phy_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model
  int   m_regs [int];
  int   m_addr, m_wb, m_rb, m_caddr, m_cwd;
  bit   m_wr, m_rd, m_ack, m_wstb, m_rstb;

  task automatic model_clear();
    m_regs.delete();
    for (int a = 0; a < 9; a++) m_regs[a] = 0;
    m_addr = 0; m_wb = 0; m_rb = 0; m_caddr = 0; m_cwd = 0;
    m_wr = 0; m_rd = 0; m_ack = 0; m_wstb = 0; m_rstb = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_clear();
    end else begin
      bit ow, orr, os, pend, nws, nrs;
      ow = m_wr; orr = m_rd; os = m_wstb || m_rstb;
      pend = m_ack || os;
      nws = 0; nrs = 0;
      if (m_wstb) begin
        if (m_caddr < 9) m_regs[m_caddr] = m_cwd;
        m_ack = 1;
      end
      if (m_rstb) begin
        m_rb = (m_caddr < 9) ? m_regs[m_caddr] : 0;
        m_ack = 1;
      end
      if (bus_wr) begin
        if (!pend && bus_wdata[24] && !ow) begin
          nws = 1; m_caddr = bus_wdata[7:0]; m_cwd = bus_wdata[15:8];
        end else if (!pend && bus_wdata[25] && !orr) begin
          nrs = 1; m_caddr = bus_wdata[7:0];
        end
        if (bus_wdata[25:24] == 2'b00 && !os) m_ack = 0;
        m_addr = bus_wdata[7:0]; m_wb = bus_wdata[15:8];
        m_wr = bus_wdata[24]; m_rd = bus_wdata[25];
      end
      m_wstb = nws; m_rstb = nrs;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] ew;
      ew = {5'b0, m_ack, m_rd, m_wr, 8'(m_rb), 8'(m_wb), 8'(m_addr)};
      chk(bus_rdata == ew, "R2/R5/R6 port word vs model", bus_rdata, ew);
      chk({phy_wr_stb, phy_rd_stb} == {m_wstb, m_rstb}, "R3 strobes vs model",
          {30'b0, phy_wr_stb, phy_rd_stb}, {30'b0, m_wstb, m_rstb});
      if (phy_wr_stb) begin
        wr_count++;
        chk({phy_addr, phy_wdata} == {8'(m_caddr), 8'(m_cwd)}, "R3 phy addr/data",
            {16'b0, phy_addr, phy_wdata}, {16'b0, 8'(m_caddr), 8'(m_cwd)});
      end
      if (phy_rd_stb) rd_count++;
    end
  end

  task automatic bw(input logic [31:0] w);
    bus_wr = 1'b1; bus_wdata = w;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input int a, input int d, input bit w, input bit r);
    return {6'b0, r, w, 8'h00, 8'(d), 8'(a)};
  endfunction

  task automatic phy_wr(input int a, input int d);
    int c0;
    c0 = wr_count;
    bw(mk(a, d, 0, 0));
    bw(mk(a, d, 1, 0));
    idle(1);
    chk(bus_rdata[26] == 1'b1, "R6 ack after write", bus_rdata, 32'h0400_0000);
    bw(mk(a, d, 0, 0));
    chk(bus_rdata[26] == 1'b0, "R7 ack cleared", bus_rdata, 32'h0);
    chk(wr_count == c0 + 1, "R3 one strobe per write", wr_count, c0 + 1);
  endtask

  task automatic phy_rd(input int a, output int v);
    bw(mk(a, 0, 0, 0));
    bw(mk(a, 0, 0, 1));
    idle(1);
    v = bus_rdata[23:16];
    chk(bus_rdata[26] == 1'b1, "R5 ack after read", bus_rdata, 32'h0400_0000);
    bw(mk(a, 0, 0, 0));
  endtask

  initial begin
    int v, c0, c1;
    int exp_vals [9] = '{4, 4, 8'h11, 8'h22, 8'h33, 8'h44, 9, 2, 3};
    rst_n = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    idle(3);
    chk(bus_rdata == 32'h0, "R1 reset word", bus_rdata, 32'h0);
    chk(!phy_wr_stb && !phy_rd_stb, "R1 reset strobes", {phy_wr_stb, phy_rd_stb}, 0);
    rst_n = 1'b1;
    idle(2);
    phy_rd(8, v);
    chk(v == 0, "R1 reg reset zero", v, 0);

    bw(32'hFFFF_A5C3 & ~32'h0300_0000);
    chk(bus_rdata == 32'h0000_A5C3, "R2 field store/readonly", bus_rdata, 32'h0000_A5C3);
    bw(32'h0);

    // R11 initialisation sequence plus UHS entries
    phy_wr(0, 4); phy_wr(1, 4); phy_wr(6, 9); phy_wr(7, 2); phy_wr(8, 3);
    phy_wr(2, 8'h11); phy_wr(3, 8'h22); phy_wr(4, 8'h33); phy_wr(5, 8'h44);
    for (int a = 0; a < 9; a++) begin
      phy_rd(a, v);
      chk(v == exp_vals[a], $sformatf("R11 readback addr %0d", a), v, exp_vals[a]);
    end

    // R10 out of range
    phy_wr(9, 8'h5A);
    phy_wr(8'hFF, 8'h6B);
    phy_rd(9, v);    chk(v == 0, "R10 read addr 9", v, 0);
    phy_rd(8'hFF, v); chk(v == 0, "R10 read addr ff", v, 0);
    phy_rd(8, v);    chk(v == 3, "R10 addr 8 untouched", v, 3);

    // R4 holding write bit high
    c0 = wr_count;
    bw(mk(2, 8'h99, 0, 0));
    bw(mk(2, 8'h99, 1, 0));
    bw(mk(2, 8'h98, 1, 0));
    idle(2);
    bw(mk(2, 8'h97, 1, 0));
    idle(2);
    chk(wr_count == c0 + 1, "R4 held bit no repeat", wr_count, c0 + 1);
    bw(32'h0);
    phy_rd(2, v); chk(v == 8'h99, "R4 first write only", v, 8'h99);

    // R8 command ignored while pending
    bw(mk(1, 0, 0, 0));
    bw(mk(1, 0, 0, 1));
    idle(1);
    c0 = wr_count;
    bw(mk(1, 8'h77, 1, 1));
    idle(2);
    chk(wr_count == c0, "R8 pending write ignored", wr_count, c0);
    bw(32'h0);
    phy_rd(1, v); chk(v == 4, "R8 reg unchanged", v, 4);

    // R9 simultaneous rise
    c0 = wr_count; c1 = rd_count;
    bw(mk(7, 8'h3C, 0, 0));
    bw(mk(7, 8'h3C, 1, 1));
    idle(2);
    chk(wr_count == c0 + 1 && rd_count == c1, "R9 write wins",
        {wr_count[15:0], rd_count[15:0]}, {16'(c0 + 1), 16'(c1)});
    bw(32'h0);
    phy_rd(7, v); chk(v == 8'h3C, "R9 write landed", v, 8'h3C);

    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule